// File: doc/BRIEF.md
# Receive Credit Gate with Flush

This block sits between a MAC receive word stream and the receive FIFO that buffers frames for the application. It owns the credit counter that bounds how many words may sit in the FIFO. Software stages a credit value in one register and arms the gate by writing a second register. Only then does the counter take that value and frames start to pass. Until the first arm, every incoming frame is thrown away. Each word written to the FIFO costs one credit, and each word the application reads back returns one.

Writing the arm register again while traffic is running re-arms the gate. The receive in progress is abandoned, and a flush request is held for a fixed number of cycles so the FIFO can drop its contents. If the application was in the middle of reading a frame, the block signals that the read side must close it with a final word that carries end-of-packet and error together. A soft-reset register clears the credit to zero and disarms the gate. After any arm or soft reset, words are accepted again only from the next start-of-frame, so the FIFO never receives a partial frame.

Top module: `rx_credit_gate`

## Requirements
- R1: After rst_ni is released, fifo_wr_o, flush_o and app_abort_o are low, credit_o is 0 and the gate is disarmed.
- R2: While the gate has never been armed (or has been disarmed by soft reset), no word reaches fifo_wr_o, whatever the receive stream carries.
- R3: Writing address 1 (arm) loads the value last written to address 0 (credit init) into credit_o on the next clock. Each accepted word appears on fifo_wr_o/fifo_data_o one cycle after it is presented, with fifo_sop_o/fifo_eop_o copied from the input, and lowers credit_o by one.
- R4: A frame whose start-of-frame word arrives while credit_o is 0 is dropped whole: none of its words are written.
- R5: If a frame is accepted with too little credit, the word that uses the last credit is written with fifo_eop_o and fifo_err_o both high, and the rest of that frame is dropped.
- R6: Each cycle with app_rd_i high (outside flush and arm/reset cycles) adds one to credit_o, which saturates at its maximum value of 2^CW-1.
- R7: An arm or soft-reset write raises flush_o for exactly FLUSH_CYCLES cycles starting the next cycle. Any receive word presented during the write cycle or while flush_o is high is dropped, and so is the remainder of the frame that was in progress.
- R8: After an arm or soft reset, the first word written to the FIFO is a start-of-frame word. Non-start words that arrive before the next start-of-frame are dropped.
- R9: If the application has read a word without end-of-packet (app_rd_i with app_rd_eop_i low) and not yet read the closing word, an arm or soft reset makes app_abort_o high for exactly one cycle, the cycle after the write. Otherwise app_abort_o stays low.
- R10: A write to address 2 (soft reset) sets credit_o to 0, disarms the gate and flushes as in R7.
- R11: A write to address 0 alone changes neither credit_o nor the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 credit init, 1 arm, 2 soft reset |
| reg_wdata_i | input | CW | Register write data (used at address 0) |
| rx_valid_i | input | 1 | Receive word valid |
| rx_data_i | input | DW | Receive word data |
| rx_sop_i | input | 1 | Receive word is start of frame |
| rx_eop_i | input | 1 | Receive word is end of frame |
| app_rd_i | input | 1 | Application read one word from the FIFO (returns one credit) |
| app_rd_eop_i | input | 1 | The word read carries end-of-packet |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | DW | FIFO write data |
| fifo_sop_o | output | 1 | Written word is start of frame |
| fifo_eop_o | output | 1 | Written word is end of frame |
| fifo_err_o | output | 1 | Written word ends a truncated frame |
| flush_o | output | 1 | FIFO flush request |
| app_abort_o | output | 1 | Read side must emit a final word with EOP and error |
| credit_o | output | CW | Current credit |

## Verification
The bench goes after frames that need exactly the available credit, one word more than it, and zero credit at start-of-frame. A gate off by one would either truncate a frame that fits or overrun the FIFO by a word. It re-arms in the middle of a frame and then sends the tail and a new frame during and after the flush window, so a design that resumed mid-frame or forwarded words during the flush would write a headless fragment. It also arms while an application read is open and again after it has closed. A design that ignored read state would miss the EOP-with-error word or produce a spurious one. Credit saturation and the rule that a staged value does nothing without the arm write are checked through credit_o.

// File: rtl/rxcg_pkg.sv
package rxcg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_DROP = 2'd2
  } rx_state_e;

  localparam logic [1:0] ADDR_INIT = 2'd0;
  localparam logic [1:0] ADDR_ARM  = 2'd1;
  localparam logic [1:0] ADDR_SRST = 2'd2;
endpackage

// File: rtl/rxcg_regs.sv
module rxcg_regs #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] init_val_o,
  output logic          arm_o,
  output logic          srst_o,
  output logic          armed_o
);
  import rxcg_pkg::*;

  assign arm_o  = we_i && (addr_i == ADDR_ARM);
  assign srst_o = we_i && (addr_i == ADDR_SRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_val_o <= '0;
      armed_o    <= 1'b0;
    end else begin
      if (we_i && (addr_i == ADDR_INIT)) init_val_o <= wdata_i;
      if (srst_o)     armed_o <= 1'b0;
      else if (arm_o) armed_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rxcg_credit.sv
module rxcg_credit #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          take_i,
  input  logic          give_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    if (clr_i)                   cnt_d = '0;
    else if (load_i)             cnt_d = load_val_i;
    else if (take_i && !give_i)  cnt_d = cnt_o - 1'b1;
    else if (give_i && !take_i && cnt_o != CMAX) cnt_d = cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/rxcg_flush.sv
module rxcg_flush #(
  parameter int FLUSH_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic app_rd_i,
  input  logic app_rd_eop_i,
  output logic busy_o,
  output logic app_abort_o
);
  localparam int FW = $clog2(FLUSH_CYCLES + 1);

  logic [FW-1:0] fcnt_q;
  logic          app_open_q;
  logic          rd_ok;
  logic          open_now;

  assign busy_o   = (fcnt_q != '0);
  assign rd_ok    = app_rd_i && !busy_o;
  assign open_now = app_open_q ? !(rd_ok && app_rd_eop_i) : (rd_ok && !app_rd_eop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q      <= '0;
      app_open_q  <= 1'b0;
      app_abort_o <= 1'b0;
    end else begin
      if (restart_i)   fcnt_q <= FW'(FLUSH_CYCLES);
      else if (busy_o) fcnt_q <= fcnt_q - 1'b1;
      if (restart_i) begin
        app_abort_o <= open_now;
        app_open_q  <= 1'b0;
      end else begin
        app_abort_o <= 1'b0;
        app_open_q  <= open_now;
      end
    end
  end
endmodule

// File: rtl/rxcg_gate.sv
module rxcg_gate #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kill_i,
  input  logic          armed_i,
  input  logic [CW-1:0] credit_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_sop_i,
  input  logic          rx_eop_i,
  output logic          take_o,
  output logic          fifo_wr_o,
  output logic [DW-1:0] fifo_data_o,
  output logic          fifo_sop_o,
  output logic          fifo_eop_o,
  output logic          fifo_err_o
);
  import rxcg_pkg::*;

  rx_state_e state_q, state_d;
  logic      trunc;
  logic      has_credit;
  logic      last_credit;

  assign has_credit  = (credit_i != '0);
  assign last_credit = (credit_i == CW'(1));

  always_comb begin
    state_d = state_q;
    take_o  = 1'b0;
    trunc   = 1'b0;
    if (kill_i) begin
      state_d = ST_IDLE;
    end else if (rx_valid_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (rx_sop_i) begin
            if (armed_i && has_credit) begin
              take_o  = 1'b1;
              trunc   = last_credit && !rx_eop_i;
              state_d = rx_eop_i ? ST_IDLE : (trunc ? ST_DROP : ST_PASS);
            end else begin
              state_d = rx_eop_i ? ST_IDLE : ST_DROP;
            end
          end
        end
        ST_PASS: begin
          if (has_credit) begin
            take_o  = 1'b1;
            trunc   = last_credit && !rx_eop_i;
            state_d = rx_eop_i ? ST_IDLE : (trunc ? ST_DROP : ST_PASS);
          end else begin
            state_d = rx_eop_i ? ST_IDLE : ST_DROP;
          end
        end
        ST_DROP: begin
          if (rx_eop_i) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      fifo_wr_o   <= 1'b0;
      fifo_data_o <= '0;
      fifo_sop_o  <= 1'b0;
      fifo_eop_o  <= 1'b0;
      fifo_err_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      fifo_wr_o  <= take_o;
      fifo_sop_o <= take_o && rx_sop_i;
      fifo_eop_o <= take_o && (rx_eop_i || trunc);
      fifo_err_o <= take_o && trunc;
      if (take_o) fifo_data_o <= rx_data_i;
    end
  end
endmodule

// File: rtl/rx_credit_gate.sv
module rx_credit_gate #(
  parameter int DW           = 32,
  parameter int CW           = 8,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [CW-1:0] reg_wdata_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_sop_i,
  input  logic          rx_eop_i,
  input  logic          app_rd_i,
  input  logic          app_rd_eop_i,
  output logic          fifo_wr_o,
  output logic [DW-1:0] fifo_data_o,
  output logic          fifo_sop_o,
  output logic          fifo_eop_o,
  output logic          fifo_err_o,
  output logic          flush_o,
  output logic          app_abort_o,
  output logic [CW-1:0] credit_o
);
  logic [CW-1:0] init_val;
  logic          arm, srst, armed, restart, busy, take, give;

  assign restart = arm || srst;
  assign give    = app_rd_i && !busy && !restart;
  assign flush_o = busy;

  rxcg_regs #(.CW(CW)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .init_val_o(init_val),
    .arm_o     (arm),
    .srst_o    (srst),
    .armed_o   (armed)
  );

  rxcg_flush #(.FLUSH_CYCLES(FLUSH_CYCLES)) i_flush (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart),
    .app_rd_i    (app_rd_i),
    .app_rd_eop_i(app_rd_eop_i),
    .busy_o      (busy),
    .app_abort_o (app_abort_o)
  );

  rxcg_credit #(.CW(CW)) i_credit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (srst),
    .load_i    (arm),
    .load_val_i(init_val),
    .take_i    (take),
    .give_i    (give),
    .cnt_o     (credit_o)
  );

  rxcg_gate #(.DW(DW), .CW(CW)) i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kill_i     (restart || busy),
    .armed_i    (armed),
    .credit_i   (credit_o),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_sop_i   (rx_sop_i),
    .rx_eop_i   (rx_eop_i),
    .take_o     (take),
    .fifo_wr_o  (fifo_wr_o),
    .fifo_data_o(fifo_data_o),
    .fifo_sop_o (fifo_sop_o),
    .fifo_eop_o (fifo_eop_o),
    .fifo_err_o (fifo_err_o)
  );
endmodule

// File: rtl/rxcg_checker.sv
module rxcg_checker #(
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_wr_o,
  input logic          fifo_sop_o,
  input logic          fifo_eop_o,
  input logic          fifo_err_o,
  input logic          flush_o,
  input logic          app_rd_i,
  input logic          app_abort_o,
  input logic [CW-1:0] credit_o
);
  logic need_sop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        need_sop_q <= 1'b1;
    else if (flush_o)   need_sop_q <= 1'b1;
    else if (fifo_wr_o) need_sop_q <= 1'b0;
  end

  p_no_write_in_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !fifo_wr_o);

  p_err_ends_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && fifo_err_o) |-> fifo_eop_o);

  p_write_needs_credit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> ($past(credit_o) != '0));

  p_credit_spent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && !$past(app_rd_i)) |-> ((credit_o + 1'b1) == $past(credit_o)));

  p_first_is_sop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && need_sop_q) |-> fifo_sop_o);

  p_abort_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_abort_o |=> !app_abort_o);
endmodule

bind rx_credit_gate rxcg_checker #(.CW(CW)) i_rxcg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_wr_o  (fifo_wr_o),
  .fifo_sop_o (fifo_sop_o),
  .fifo_eop_o (fifo_eop_o),
  .fifo_err_o (fifo_err_o),
  .flush_o    (flush_o),
  .app_rd_i   (app_rd_i),
  .app_abort_o(app_abort_o),
  .credit_o   (credit_o)
);

// File: tb/test_rx_credit_gate.sv
module test_rx_credit_gate;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam int FL = 4;

  typedef struct packed {
    logic [7:0] init;
    logic [7:0] len;
    logic [7:0] exp_w;
    logic       exp_err;
    logic [7:0] exp_cr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'd8,   8'd3, 8'd3, 1'b0, 8'd5},
    '{8'd3,   8'd3, 8'd3, 1'b0, 8'd0},
    '{8'd2,   8'd5, 8'd2, 1'b1, 8'd0},
    '{8'd0,   8'd4, 8'd0, 1'b0, 8'd0},
    '{8'd1,   8'd1, 8'd1, 1'b0, 8'd0},
    '{8'd1,   8'd3, 8'd1, 1'b1, 8'd0},
    '{8'd255, 8'd6, 8'd6, 1'b0, 8'd249}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          rx_sop = 1'b0;
  logic          rx_eop = 1'b0;
  logic          app_rd = 1'b0;
  logic          app_rd_eop = 1'b0;
  logic          fifo_wr, fifo_sop, fifo_eop, fifo_err, flush, app_abort;
  logic [DW-1:0] fifo_data;
  logic [CW-1:0] credit;

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0, sop_cnt = 0, flush_cnt = 0, abort_cnt = 0;
  logic last_eop = 1'b0, last_err = 1'b0;
  logic [DW-1:0] last_data = '0;

  always #5 clk = ~clk;

  rx_credit_gate #(.DW(DW), .CW(CW), .FLUSH_CYCLES(FL)) i_rx_credit_gate (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_sop_i(rx_sop), .rx_eop_i(rx_eop),
    .app_rd_i(app_rd), .app_rd_eop_i(app_rd_eop),
    .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data), .fifo_sop_o(fifo_sop),
    .fifo_eop_o(fifo_eop), .fifo_err_o(fifo_err),
    .flush_o(flush), .app_abort_o(app_abort), .credit_o(credit)
  );

  always @(negedge clk) begin
    if (fifo_wr) begin
      wr_cnt    <= wr_cnt + 1;
      if (fifo_sop) sop_cnt <= sop_cnt + 1;
      last_eop  <= fifo_eop;
      last_err  <= fifo_err;
      last_data <= fifo_data;
    end
    if (flush)     flush_cnt <= flush_cnt + 1;
    if (app_abort) abort_cnt <= abort_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic arm(input logic [CW-1:0] v);
    reg_wr(2'd0, v);
    reg_wr(2'd1, '0);
    repeat (FL + 2) @(negedge clk);
  endtask

  task automatic send_words(input int len, input logic [DW-1:0] base,
                            input bit with_sop);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sop   = with_sop && (i == 0);
      rx_eop   = (i == len - 1);
      rx_data  = base + DW'(i);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic app_read(input bit eop);
    @(negedge clk);
    app_rd = 1'b1; app_rd_eop = eop;
    @(negedge clk);
    app_rd = 1'b0; app_rd_eop = 1'b0;
  endtask

  initial begin
    int w0, s0, f0, a0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fifo_wr == 1'b0, "R1", "fifo_wr in reset", fifo_wr, 0);
    chk(flush == 1'b0, "R1", "flush in reset", flush, 0);
    chk(app_abort == 1'b0, "R1", "abort in reset", app_abort, 0);
    chk(credit == '0, "R1", "credit in reset", credit, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 staging alone does nothing; R2 unarmed drops
    reg_wr(2'd0, 8'd6);
    repeat (2) @(negedge clk);
    chk(credit == '0, "R11", "credit after init write only", credit, 0);
    w0 = wr_cnt;
    send_words(3, 32'h11, 1'b1);
    chk(wr_cnt == w0, "R2", "words written while unarmed", wr_cnt - w0, 0);

    // vector table: R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      arm(VEC[v].init);
      chk(credit == VEC[v].init, "R3", "credit after arm", credit, VEC[v].init);
      w0 = wr_cnt; s0 = sop_cnt;
      send_words(int'(VEC[v].len), 32'hA000 + DW'(v * 16), 1'b1);
      chk(wr_cnt - w0 == int'(VEC[v].exp_w), VEC[v].exp_w == 0 ? "R4" : "R5",
          "words written", wr_cnt - w0, VEC[v].exp_w);
      chk(credit == VEC[v].exp_cr, "R3", "credit after frame", credit, VEC[v].exp_cr);
      if (VEC[v].exp_w != 0) begin
        chk(sop_cnt - s0 == 1, "R3", "sop count", sop_cnt - s0, 1);
        chk(last_eop == 1'b1, "R5", "last word eop", last_eop, 1);
        chk(last_err == VEC[v].exp_err, "R5", "last word err", last_err, VEC[v].exp_err);
        chk(last_data == 32'hA000 + DW'(v * 16) + DW'(VEC[v].exp_w) - 1, "R3",
            "last data", last_data, 32'hA000 + v * 16 + VEC[v].exp_w - 1);
      end
    end

    // R6 credit return and saturation
    arm(8'd5);
    app_read(1'b1); app_read(1'b1);
    @(negedge clk);
    chk(credit == 8'd7, "R6", "credit after two returns", credit, 7);
    arm(8'd250);
    @(negedge clk);
    app_rd = 1'b1; app_rd_eop = 1'b1;
    repeat (10) @(negedge clk);
    app_rd = 1'b0; app_rd_eop = 1'b0;
    @(negedge clk);
    chk(credit == 8'd255, "R6", "credit saturates", credit, 255);

    // R7 R8 re-arm mid-frame
    arm(8'd10);
    w0 = wr_cnt;
    @(negedge clk); rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b0; rx_data = 32'h501;
    @(negedge clk); rx_sop = 1'b0; rx_data = 32'h502;
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
    chk(wr_cnt - w0 == 2, "R7", "words before re-arm", wr_cnt - w0, 2);
    f0 = flush_cnt;
    reg_wr(2'd1, '0);
    w0 = wr_cnt;
    send_words(3, 32'h600, 1'b1);
    chk(flush_cnt - f0 == FL, "R7", "flush cycles", flush_cnt - f0, FL);
    chk(wr_cnt == w0, "R7", "words during flush", wr_cnt - w0, 0);
    chk(credit == 8'd10, "R7", "credit reloaded", credit, 10);
    w0 = wr_cnt;
    send_words(2, 32'h700, 1'b0);
    chk(wr_cnt == w0, "R8", "tail words after flush", wr_cnt - w0, 0);
    s0 = sop_cnt;
    send_words(3, 32'h800, 1'b1);
    chk(wr_cnt - w0 == 3, "R8", "new frame words", wr_cnt - w0, 3);
    chk(sop_cnt - s0 == 1, "R8", "new frame sop", sop_cnt - s0, 1);
    chk(last_data == 32'h802, "R8", "new frame last data", last_data, 32'h802);

    // R9 abort of an open application transfer
    arm(8'd5);
    a0 = abort_cnt;
    app_read(1'b0);
    reg_wr(2'd1, '0);
    repeat (FL + 2) @(negedge clk);
    chk(abort_cnt - a0 == 1, "R9", "abort with open read", abort_cnt - a0, 1);
    a0 = abort_cnt;
    reg_wr(2'd1, '0);
    repeat (FL + 2) @(negedge clk);
    chk(abort_cnt == a0, "R9", "abort with nothing open", abort_cnt - a0, 0);
    app_read(1'b0); app_read(1'b1);
    reg_wr(2'd1, '0);
    repeat (FL + 2) @(negedge clk);
    chk(abort_cnt == a0, "R9", "abort after closed read", abort_cnt - a0, 0);

    // R10 soft reset
    arm(8'd9);
    f0 = flush_cnt;
    reg_wr(2'd2, '0);
    repeat (FL + 2) @(negedge clk);
    chk(credit == '0, "R10", "credit after soft reset", credit, 0);
    chk(flush_cnt - f0 == FL, "R10", "flush cycles on soft reset", flush_cnt - f0, FL);
    w0 = wr_cnt;
    send_words(2, 32'h900, 1'b1);
    chk(wr_cnt == w0, "R10", "words after soft reset", wr_cnt - w0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule